// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 16-bit successive-approximation converter. A start pulse puts the block into its busy state and moves the hold/track output to hold. When the start pulse falls, the result register is loaded with its inactive pattern, and a gated bit clock begins to run. On each rising edge of that clock the sequencer either puts the next bit on trial or records the comparator's verdict on the bit under test. It works from the most significant bit downward. The register contents are always visible on the DAC drive port.

The result uses complementary coding, so a bit the comparator kept reads 0. This gives complementary straight binary on unipolar ranges and complementary offset binary on bipolar ranges. A configuration input can flip only the top bit of the output word, which turns the result into a two's-complement-style code.

A short-cycle count, taken when the start pulse falls, ends the run after that many decisions. Busy then drops, the bit clock parks low and the hold/track output returns to track.

Top module: `sarConvSeq`

## Requirements
- R1: When startReq rises while busy is 0, busy and holdOut are both 1 one clock later.
- R2: The clock edge that sees startReq fall after an accepted rise sets every result bit to 1, the inactive state. dataOut then reads 16'hFFFF, with bit 15 flipped when invertMsb is 1.
- R3: Bits are decided from bit 15 down. A bit under trial is driven as 0. A decision writes 0 when cmpIn is 1 (kept) and 1 when cmpIn is 0. dacCode always equals the result register. With an ideal comparator, a full run gives dataOut = ~vin.
- R4: During a run, bitClkOut toggles on every clock and gives exactly N+1 rising edges for a run of N decisions. bitClkOut is 0 whenever busy is 0.
- R5: The decision count N is taken from bitLimit when startReq falls. A value of 0 or above 16 means 16. Busy falls 2N+3 clocks after the edge that accepted the start rise. The lower 16-N bits stay at 1.
- R6: The final result is on dataOut one clock before busy falls and does not change on the edge where busy falls.
- R7: holdOut falls on the same edge as busy.
- R8: A start pulse that arrives while busy is 1 has no effect on the result, on the run length, or on the bit clock.
- R9: invertMsb flips only dataOut[15]. dacCode is not affected by it.
- R10: After reset, busy, bitClkOut and holdOut are 0 and dataOut is 16'hFFFF, with bit 15 flipped when invertMsb is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse: the rise arms a run and the fall begins it |
| bitLimit | input | 5 | Short-cycle decision count (0 or >16 means 16) |
| invertMsb | input | 1 | Flip dataOut[15] for a two's-complement-style code |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the DAC trial value |
| dacCode | output | 16 | Result register driven to the feedback DAC |
| dataOut | output | 16 | Parallel result in complementary coding |
| busy | output | 1 | Conversion in progress |
| bitClkOut | output | 1 | Gated bit clock, parked low when idle |
| holdOut | output | 1 | 1 = hold, 0 = track |

## Verification
Count from the edge that accepts the start rise. Busy and hold appear one edge later. The register is initialized on the next edge. Trial and decision updates land on every second edge after that. The final decision lands at edge 2N+2, and busy and hold fall at edge 2N+3. The bench drives inputs and samples outputs on falling clock edges and counts those edges from the accepted start. It then compares the count at which busy is first seen low with 2N+3. It also checks the word sampled one edge earlier, the number of bitClkOut rises, and the register state one edge after the start falls.

// File: rtl/sarConvSeqPkg.sv
package sarConvSeqPkg;
  localparam int SAR_BITS = 16;
  localparam int IDX_W    = $clog2(SAR_BITS);
  localparam int LIM_W    = $clog2(SAR_BITS + 1);

  typedef struct packed {
    logic             init;
    logic             trial;
    logic [IDX_W-1:0] trialIdx;
    logic             decide;
    logic [IDX_W-1:0] decIdx;
  } seqStrobe_t;
endpackage

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl
  import sarConvSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LIM_W-1:0] bitLimit,
  output seqStrobe_t       strobe,
  output logic             busy,
  output logic             bitClk,
  output logic             holdOut
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN} seqState_t;

  seqState_t        state;
  logic             startPrev;
  logic             lastStep;
  logic [LIM_W-1:0] stepCnt;
  logic [LIM_W-1:0] limitReg;
  logic [LIM_W-1:0] effLimit;
  logic             riseEv;
  logic             fallEv;
  logic             stepNow;
  logic             finalDec;

  assign riseEv   = startReq & ~startPrev;
  assign fallEv   = ~startReq & startPrev;
  assign effLimit = (bitLimit == '0 || bitLimit > LIM_W'(SAR_BITS))
                    ? LIM_W'(SAR_BITS) : bitLimit;
  assign stepNow  = (state == S_RUN) && !bitClk;
  assign finalDec = (stepCnt != '0) && (stepCnt == limitReg);

  // Strobes for the datapath: one step per rising edge of the bit clock
  always_comb begin
    strobe      = '0;
    strobe.init = (state == S_ARMED) && fallEv;
    if (stepNow) begin
      if (stepCnt == '0) begin
        strobe.trial    = 1'b1;
        strobe.trialIdx = IDX_W'(SAR_BITS - 1);
      end else begin
        strobe.decide = 1'b1;
        strobe.decIdx = IDX_W'(SAR_BITS - int'(stepCnt));
        if (!finalDec) begin
          strobe.trial    = 1'b1;
          strobe.trialIdx = IDX_W'(SAR_BITS - 1 - int'(stepCnt));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      startPrev <= 1'b0;
      lastStep  <= 1'b0;
      stepCnt   <= '0;
      limitReg  <= LIM_W'(SAR_BITS);
      busy      <= 1'b0;
      bitClk    <= 1'b0;
      holdOut   <= 1'b0;
    end else begin
      startPrev <= startReq;
      unique case (state)
        S_IDLE: begin
          if (riseEv) begin
            state   <= S_ARMED;
            busy    <= 1'b1;
            holdOut <= 1'b1;
          end
        end
        S_ARMED: begin
          if (fallEv) begin
            state    <= S_RUN;
            bitClk   <= 1'b0;
            stepCnt  <= '0;
            lastStep <= 1'b0;
            limitReg <= effLimit;
          end
        end
        S_RUN: begin
          if (bitClk) begin
            bitClk <= 1'b0;
            if (lastStep) begin
              state   <= S_IDLE;
              busy    <= 1'b0;
              holdOut <= 1'b0;
            end
          end else begin
            bitClk  <= 1'b1;
            stepCnt <= stepCnt + 1'b1;
            if (finalDec) lastStep <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sarSeqData.sv
module sarSeqData
  import sarConvSeqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                cmpIn,
  input  logic                invertMsb,
  output logic [SAR_BITS-1:0] dacCode,
  output logic [SAR_BITS-1:0] dataOut
);
  logic [SAR_BITS-1:0] resReg;

  for (genvar i = 0; i < SAR_BITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)                                          resReg[i] <= 1'b1;
      else if (strobe.init)                               resReg[i] <= 1'b1;
      else if (strobe.trial  && strobe.trialIdx == IDX_W'(i)) resReg[i] <= 1'b0;
      else if (strobe.decide && strobe.decIdx   == IDX_W'(i)) resReg[i] <= ~cmpIn;
    end
  end

  assign dacCode = resReg;
  assign dataOut = {resReg[SAR_BITS-1] ^ invertMsb, resReg[SAR_BITS-2:0]};
endmodule

// File: rtl/sarConvSeq.sv
module sarConvSeq
  import sarConvSeqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [LIM_W-1:0]    bitLimit,
  input  logic                invertMsb,
  input  logic                cmpIn,
  output logic [SAR_BITS-1:0] dacCode,
  output logic [SAR_BITS-1:0] dataOut,
  output logic                busy,
  output logic                bitClkOut,
  output logic                holdOut
);
  seqStrobe_t strobe;

  sarSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .bitLimit (bitLimit),
    .strobe   (strobe),
    .busy     (busy),
    .bitClk   (bitClkOut),
    .holdOut  (holdOut)
  );

  sarSeqData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpIn     (cmpIn),
    .invertMsb (invertMsb),
    .dacCode   (dacCode),
    .dataOut   (dataOut)
  );
endmodule

// File: rtl/sarConvSeq_chk.sv
module sarConvSeq_chk
  import sarConvSeqPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic [SAR_BITS-1:0] dacCode,
  input logic [SAR_BITS-1:0] dataOut,
  input logic                busy,
  input logic                bitClkOut,
  input logic                holdOut
);
  // R1: an accepted start raises busy and hold on the next edge
  a_r1_start_arms: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(startReq) && !busy) |=> (busy && holdOut));

  // R4: the bit clock is parked low whenever the block is idle
  a_r4_clk_parked: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !bitClkOut);

  // R3: the DAC word moves only with a bit clock rise or the start fall
  a_r3_dac_moves_on_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> ($rose(bitClkOut) || ($past(startReq, 2) && !$past(startReq))));

  // R6: the result does not change on the edge where busy falls
  a_r6_data_settled: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $stable(dataOut));

  // R7: hold is released together with busy
  a_r7_track_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !holdOut);
endmodule

bind sarConvSeq sarConvSeq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .dacCode   (dacCode),
  .dataOut   (dataOut),
  .busy      (busy),
  .bitClkOut (bitClkOut),
  .holdOut   (holdOut)
);

// File: tb/sarConvSeq_bench.sv
`timescale 1ns/1ps
module sarConvSeq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [4:0]  bitLimit = 5'd16;
  logic        invertMsb = 1'b0;
  logic        cmpIn;
  logic [15:0] dacCode, dataOut;
  logic        busy, bitClkOut, holdOut;
  logic [15:0] vin = 16'h0;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  // ideal comparator: input >= true-binary trial word
  assign cmpIn = (vin >= ~dacCode);

  sarConvSeq u_sarConvSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitLimit(bitLimit),
    .invertMsb(invertMsb), .cmpIn(cmpIn), .dacCode(dacCode), .dataOut(dataOut),
    .busy(busy), .bitClkOut(bitClkOut), .holdOut(holdOut)
  );

  // {vin, bitLimit, invertMsb}
  localparam logic [21:0] VEC [12] = '{
    {16'hA5C3, 5'd16, 1'b0}, {16'h0000, 5'd16, 1'b0}, {16'hFFFF, 5'd16, 1'b0},
    {16'h1234, 5'd8,  1'b0}, {16'hBEEF, 5'd10, 1'b1}, {16'h7FFF, 5'd12, 1'b0},
    {16'h8000, 5'd13, 1'b1}, {16'hC0DE, 5'd14, 1'b0}, {16'h5555, 5'd15, 1'b0},
    {16'h9ABC, 5'd0,  1'b0}, {16'h3C3C, 5'd20, 1'b1}, {16'hFFFF, 5'd1,  1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int effN(input logic [4:0] lim);
    return (lim == 0 || lim > 16) ? 16 : int'(lim);
  endfunction

  task automatic runConv(input logic [15:0] v, input logic [4:0] lim,
                         input logic inv, input bit poke);
    int n = effN(lim);
    logic [15:0] mask = 16'hFFFF << (16 - n);
    logic [15:0] expDac = ~(v & mask);
    logic [15:0] expOut = expDac ^ {inv, 15'b0};
    logic [15:0] lastBusyData = 16'h0;
    int cnt = 0;
    int rises = 0;
    logic prevClk = 1'b0;
    @(negedge clk);
    vin = v; bitLimit = lim; invertMsb = inv;
    startReq = 1'b1;
    @(negedge clk);
    check(busy && holdOut, "R1 busy/hold after start", {busy, holdOut}, 3);
    startReq = 1'b0;
    while (cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1)
        check(dataOut == (16'hFFFF ^ {inv, 15'b0}), "R2 init pattern", dataOut, 16'hFFFF ^ {inv, 15'b0});
      if (poke && cnt == 5) startReq = 1'b1;
      if (poke && cnt == 7) startReq = 1'b0;
      if (bitClkOut && !prevClk) rises++;
      prevClk = bitClkOut;
      if (!busy) break;
      lastBusyData = dataOut;
    end
    check(cnt == 2*n + 3, poke ? "R8 run length with extra start" : "R5 run length", cnt, 2*n + 3);
    check(rises == n + 1, "R4 bit clock rises", rises, n + 1);
    check(dataOut == expOut, poke ? "R8 result with extra start" : "R3 R5 converted code", dataOut, expOut);
    check(lastBusyData == expOut, "R6 data before busy falls", lastBusyData, expOut);
    check(!holdOut, "R7 hold released", holdOut, 0);
    check(dacCode == expDac, "R9 dac unaffected by msb flip", dacCode, expDac);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!bitClkOut && !busy, "R4 clock parked while idle", bitClkOut, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !bitClkOut && !holdOut, "R10 reset flags", {busy, bitClkOut, holdOut}, 0);
    check(dataOut == 16'hFFFF, "R10 reset data", dataOut, 16'hFFFF);
    rstN = 1'b1;
    for (int i = 0; i < 12; i++)
      runConv(VEC[i][21:6], VEC[i][5:1], VEC[i][0], 1'b0);
    // R8: extra start pulses during a run are ignored
    runConv(16'h6A2D, 5'd16, 1'b0, 1'b1);
    runConv(16'hE001, 5'd12, 1'b1, 1'b1);
    // R3: random inputs, full and short runs
    for (int i = 0; i < 6; i++)
      runConv(16'($urandom), (i % 2) ? 5'd16 : 5'(8 + i), 1'b0, 1'b0);
    // R9: flipping invertMsb while idle moves only bit 15
    @(negedge clk);
    invertMsb = 1'b1;
    #1;
    check(dataOut == (dacCode ^ 16'h8000), "R9 msb flip only", dataOut, dacCode ^ 16'h8000);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule